// File: doc/BRIEF.md
# Duty-Cycled ADC Power Sequencer

This controller runs a sampling ADC in a closed, self-repeating low-power loop without any host. It drives the converter's active-low power-down and chip-select lines and watches the converter's active-low busy output. Each pass through the loop has four phases. The converter is powered and left to settle. A falling chip-select edge then starts a conversion. When busy returns high, power is held briefly. The converter then sleeps for a programmable interval, and the loop repeats. The sleep length sets the sample rate and the average power.

A recovery timer counts consecutive powered cycles. It restarts every time the loop reaches sleep. If the loop stays powered for too long, for example when a conversion never finishes, the timer forces chip-select high and power-down low. The loop then resumes from sleep. Every interval is a count of system clock cycles. Every timing parameter must be at least 1.

Top module: `adc_duty_seq`

## Requirements
- R1: While rst_ni is low, pd_no_o is 0, cs_no_o is 1, eoc_o is 0 and wdog_fire_o is 0. After reset the block is in the sleep phase.
- R2: The sleep phase lasts exactly SLEEP_CYC clock cycles. During it pd_no_o is 0 and cs_no_o is 1. After it, pd_no_o rises.
- R3: Once pd_no_o is high, cs_no_o stays high for exactly SETTLE_CYC cycles. It then falls while pd_no_o stays high, which starts a conversion.
- R4: busy_ni passes through two synchronizer flops, and an end of conversion is a 0-to-1 edge of the synchronized value. The edge raises eoc_o for exactly one cycle, in the second cycle after busy_ni rises, and only while cs_no_o is low.
- R5: cs_no_o returns high in the cycle after eoc_o.
- R6: After cs_no_o returns high, pd_no_o stays high for exactly HOLD_CYC cycles and then falls.
- R7: busy_ni transitions outside a conversion are ignored. They produce no eoc_o and do not change the sleep length.
- R8: If pd_no_o stays high for WDOG_CYC consecutive cycles, wdog_fire_o is 1 in the WDOG_CYC-th cycle. In the next cycle pd_no_o is 0 and cs_no_o is 1, and a full sleep phase follows.
- R9: The recovery timer restarts whenever pd_no_o is low. A normal cycle whose powered time is shorter than WDOG_CYC never raises wdog_fire_o.
- R10: cs_no_o is never low while pd_no_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| busy_ni | input | 1 | Converter busy, active low, asynchronous |
| pd_no_o | output | 1 | Converter power-down, active low |
| cs_no_o | output | 1 | Converter chip-select, active low; a falling edge starts a conversion |
| eoc_o | output | 1 | One-cycle pulse at each end of conversion |
| wdog_fire_o | output | 1 | One-cycle pulse when the recovery timer forces a restart |

## Verification
The loop is driven with conversions of one, four, six and twenty cycles. The one-cycle conversion shows that the synchronizer edge detector catches the shortest busy pulse. The twenty-cycle conversion shows that a long but legal conversion stays under the recovery limit. A busy pulse injected during sleep separates edge detection gated to the conversion phase from ungated detection. A converter that never answers drives the recovery path, and a normal cycle afterwards shows that the loop resumes. Each phase length is measured at the ports, so an off-by-one error in any timer shows up as a wrong count.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    ST_SLEEP  = 2'd0,
    ST_SETTLE = 2'd1,
    ST_CONV   = 2'd2,
    ST_HOLD   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/adc_busy_sync.sv
module adc_busy_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_ni,
  output logic rise_o
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh <= '1;
    else         sh <= {sh[STAGES-1:0], busy_ni};
  end

  assign rise_o = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/adc_cyc_counter.sv
module adc_cyc_counter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (clr_i)             cnt_o <= '0;
    else if (en_i && !(&cnt_o)) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/adc_duty_seq.sv
module adc_duty_seq
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYC  = 30,
  parameter int HOLD_CYC    = 4,
  parameter int SLEEP_CYC   = 64,
  parameter int WDOG_CYC    = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_ni,
  output logic pd_no_o,
  output logic cs_no_o,
  output logic eoc_o,
  output logic wdog_fire_o
);
  localparam int PH_MAX0 = (SETTLE_CYC > HOLD_CYC) ? SETTLE_CYC : HOLD_CYC;
  localparam int PH_MAX  = (PH_MAX0 > SLEEP_CYC) ? PH_MAX0 : SLEEP_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);
  localparam int WD_W    = $clog2(WDOG_CYC + 1);
  localparam logic [PH_W-1:0] SETTLE_LAST = PH_W'(SETTLE_CYC - 1);
  localparam logic [PH_W-1:0] HOLD_LAST   = PH_W'(HOLD_CYC - 1);
  localparam logic [PH_W-1:0] SLEEP_LAST  = PH_W'(SLEEP_CYC - 1);
  localparam logic [WD_W-1:0] WDOG_LAST   = WD_W'(WDOG_CYC - 1);

  seq_state_e      state_q, state_d;
  logic [PH_W-1:0] ph_cnt;
  logic [WD_W-1:0] wd_cnt;
  logic            eoc_rise;
  logic            wd_fire;
  logic            ph_clr;
  logic            asleep;

  adc_busy_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_ni (busy_ni),
    .rise_o  (eoc_rise)
  );

  adc_cyc_counter #(.W(PH_W)) u_phase_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (ph_clr),
    .en_i   (1'b1),
    .cnt_o  (ph_cnt)
  );

  // recovery timer: runs while powered, restarts in every sleep cycle
  adc_cyc_counter #(.W(WD_W)) u_wdog_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (asleep),
    .en_i   (!asleep),
    .cnt_o  (wd_cnt)
  );

  assign asleep  = (state_q == ST_SLEEP);
  assign wd_fire = !asleep && (wd_cnt == WDOG_LAST);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_SLEEP:  if (ph_cnt == SLEEP_LAST)  state_d = ST_SETTLE;
      ST_SETTLE: if (ph_cnt == SETTLE_LAST) state_d = ST_CONV;
      ST_CONV:   if (eoc_rise)              state_d = ST_HOLD;
      ST_HOLD:   if (ph_cnt == HOLD_LAST)   state_d = ST_SLEEP;
      default:                              state_d = ST_SLEEP;
    endcase
    if (wd_fire) state_d = ST_SLEEP;
  end

  assign ph_clr = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_SLEEP;
    else         state_q <= state_d;
  end

  assign pd_no_o     = !asleep;
  assign cs_no_o     = (state_q != ST_CONV);
  assign eoc_o       = eoc_rise && (state_q == ST_CONV);
  assign wdog_fire_o = wd_fire;
endmodule

// File: rtl/adc_duty_seq_chk.sv
module adc_duty_seq_chk #(
  parameter int WDOG_CYC = 1024
) (
  input logic clk_i,
  input logic rst_ni,
  input logic pd_no_o,
  input logic cs_no_o,
  input logic eoc_o,
  input logic wdog_fire_o
);
  localparam int WD_W = $clog2(WDOG_CYC + 2);
  logic [WD_W-1:0] on_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            on_run <= '0;
    else if (!pd_no_o)      on_run <= '0;
    else if (!(&on_run))    on_run <= on_run + 1'b1;
  end

  always @(posedge clk_i)
    if (!rst_ni)
      a_r1_reset_outputs: assert (!pd_no_o && cs_no_o && !eoc_o && !wdog_fire_o);

  a_r10_cs_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_no_o |-> cs_no_o);

  a_r3_start_while_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no_o) |-> pd_no_o && $past(pd_no_o));

  a_r4_eoc_in_conversion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |-> !cs_no_o);

  a_r4_eoc_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> !eoc_o);

  a_r5_eoc_releases_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_o |=> cs_no_o);

  a_r8_fire_forces_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_fire_o |=> (!pd_no_o && cs_no_o));

  a_r8_fire_only_powered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdog_fire_o |-> pd_no_o);

  a_r9_powered_run_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    on_run <= WD_W'(WDOG_CYC));
endmodule

bind adc_duty_seq adc_duty_seq_chk #(.WDOG_CYC(WDOG_CYC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pd_no_o     (pd_no_o),
  .cs_no_o     (cs_no_o),
  .eoc_o       (eoc_o),
  .wdog_fire_o (wdog_fire_o)
);

// File: tb/sim_adc_duty_seq.sv
module sim_adc_duty_seq;
  localparam int SETTLE = 5;
  localparam int HOLD   = 3;
  localparam int SLEEP  = 8;
  localparam int WDOG   = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic busy_n;
  logic pd_n, cs_n, eoc, fire;
  int   total = 0;
  int   bad = 0;
  int   fires = 0;

  always #5 clk = ~clk;

  adc_duty_seq #(
    .SETTLE_CYC(SETTLE), .HOLD_CYC(HOLD), .SLEEP_CYC(SLEEP), .WDOG_CYC(WDOG)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .busy_ni(busy_n),
    .pd_no_o(pd_n), .cs_no_o(cs_n), .eoc_o(eoc), .wdog_fire_o(fire)
  );

  always @(negedge clk) if (rst_n && fire) fires++;

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic test_reset();
    rst_n  = 1'b0;
    busy_n = 1'b1;
    repeat (3) step();
    chk(pd_n == 1'b0, "R1 pd_no", pd_n, 0);
    chk(cs_n == 1'b1, "R1 cs_no", cs_n, 1);
    chk(eoc == 1'b0 && fire == 1'b0, "R1 pulses", {eoc, fire}, 0);
    rst_n = 1'b1;
  endtask

  // one full loop: settle, conversion of conv_len cycles, hold, sleep
  task automatic run_cycle(input int conv_len, input bit glitch);
    int n, h, s, stray;
    while (!pd_n) step();
    n = 0;
    while (pd_n && cs_n && n < 100) begin n++; step(); end
    chk(n == SETTLE, "R3 settle length", n, SETTLE);
    chk(pd_n == 1'b1, "R10 powered at start", pd_n, 1);
    busy_n = 1'b0;
    stray = 0;
    for (int i = 0; i < conv_len; i++) begin
      step();
      if (eoc) stray++;
    end
    busy_n = 1'b1;
    step();
    chk(eoc == 1'b0 && cs_n == 1'b0, "R4 no early eoc", {eoc, cs_n}, 0);
    step();
    chk(eoc == 1'b1 && stray == 0, "R4 eoc pulse", eoc, 1);
    step();
    chk(eoc == 1'b0 && cs_n == 1'b1, "R5 cs release", {eoc, cs_n}, 1);
    h = 0;
    while (pd_n && h < 100) begin h++; step(); end
    chk(h == HOLD, "R6 hold length", h, HOLD);
    s = 0;
    stray = 0;
    while (!pd_n && s < 100) begin
      if (glitch && s == 1) busy_n = 1'b0;
      if (glitch && s == 3) busy_n = 1'b1;
      if (eoc || !cs_n) stray++;
      s++;
      step();
    end
    chk(s == SLEEP, glitch ? "R7 sleep length with busy glitch" : "R2 sleep length", s, SLEEP);
    chk(stray == 0, glitch ? "R7 no eoc outside conversion" : "R2 cs high in sleep", stray, 0);
  endtask

  task automatic test_normal();
    run_cycle(4, 1'b0);
    run_cycle(1, 1'b0);
    run_cycle(20, 1'b0);
    chk(fires == 0, "R9 no fire in normal cycles", fires, 0);
  endtask

  task automatic test_glitch();
    run_cycle(6, 1'b1);
  endtask

  task automatic test_wdog();
    int k, fire_at, base;
    base = fires;
    while (!pd_n) step();
    k = 0;
    fire_at = 0;
    while (pd_n && k < 200) begin
      k++;
      if (fire) fire_at = k;
      step();
    end
    chk(fire_at == WDOG, "R8 fire cycle", fire_at, WDOG);
    chk(pd_n == 1'b0 && cs_n == 1'b1, "R8 forced sleep", {pd_n, cs_n}, 1);
    chk(fires - base == 1, "R8 single fire", fires - base, 1);
    k = 0;
    while (!pd_n && k < 100) begin k++; step(); end
    chk(k == SLEEP, "R8 full sleep after fire", k, SLEEP);
    run_cycle(3, 1'b0);
    chk(fires - base == 1, "R9 timer restarted", fires - base, 1);
  endtask

  initial begin
    test_reset();
    test_normal();
    test_glitch();
    test_wdog();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule